// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a link to a single-channel 16-bit successive-approximation converter with a three-wire serial port. For each accepted request it pulls chip select low, produces a serial clock from the system clock through a programmable divider, shifts in one conversion frame, and returns the 16-bit sample with a one-cycle valid strobe once chip select has gone high again.

A frame consists of four framing zeros, the sample MSB first, and, in the long mode, four more framing zeros. The first framing zero is already on the data line when chip select falls. Each later bit appears after a serial clock falling edge. The reader therefore samples each bit in the system clock cycle in which it drives the serial clock low. Any framing bit that reads as 1 raises an error flag alongside the result. Between frames, chip select stays high for a programmable minimum time.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held and right after it, cs_n and sclk are 1, and busy, valid, result and frame_err are 0.
- R2: sclk is 1 whenever cs_n is 1. sclk is still 1 in the first cycle of every frame, and every frame ends with sclk at 1.
- R3: start is accepted only while cs_n is 1 and cs_n has been 1 for at least quiet_min+1 system clocks. A start held during a frame has no effect on that frame.
- R4: Each sclk half period lasts half_div+1 system clocks. cs_n stays low for exactly 2·N·(half_div+1) clocks. half_div and long_frame are captured when the request is accepted, so later changes do not affect the frame in progress.
- R5: A frame has N sclk falling edges: N=20 when long_frame=0 and N=24 when long_frame=1. The reader never ends a frame early.
- R6: Frame bits are numbered from 0, where bit 0 is the bit present when cs_n falls. Bit k is sampled in the system clock cycle that drives falling edge k+1. Bits 4 to 19 form result, with bit 4 as result[15].
- R7: frame_err is 1 if any of bits 0 to 3 was 1, or if long_frame=1 and any of bits 20 to 23 was 1. In short mode no bit past 19 is read, so those bits have no effect.
- R8: result and frame_err update, and valid is 1, only in the first cycle in which cs_n is 1 again after a complete frame. valid lasts one cycle, and result holds its value until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one conversion frame |
| long_frame | input | 1 | 1 selects the 24-clock frame, 0 the 20-clock frame |
| half_div | input | DIV_W | sclk half period in system clocks, minus one |
| quiet_min | input | QUIET_W | Minimum chip-select high time between frames, minus one |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | A frame is in progress |
| result | output | 16 | Last sample received |
| valid | output | 1 | One-cycle strobe marking a new result |
| frame_err | output | 1 | A framing bit of the last frame was 1 |

## Verification
The bound checker watches several rules on every cycle: sclk stays high whenever chip select is high, each frame has the number of falling edges its latched mode calls for, the chip-select high gap before every frame is at least the quiet minimum, and valid is a single-cycle pulse that only follows chip select rising. The bench alone can confirm that each sample bit arrives in the correct result position, the cycle length of a frame for every divider setting, the exact gap length, and how framing errors in each position and mode are reported. It does this by driving a converter model with known words across a sweep of dividers, modes and patterns.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               long_frame,
  input  logic [DIV_W-1:0]   half_div,
  input  logic [QUIET_W-1:0] quiet_min,
  input  logic               sdata,
  output logic               cs_n,
  output logic               sclk,
  output logic               busy,
  output logic [15:0]        result,
  output logic               valid,
  output logic               frame_err
);
  localparam int RES_W  = 16;
  localparam int LEAD   = 4;
  localparam int SHORTN = LEAD + RES_W;
  localparam int LONGN  = SHORTN + 4;

  logic [DIV_W-1:0]   div_q, tick;
  logic               long_q, err_q;
  logic [4:0]         nfall;
  logic [RES_W-1:0]   shreg;
  logic [QUIET_W-1:0] qcnt;

  wire       accept    = start & cs_n & (qcnt >= quiet_min);
  wire       tick_hit  = (tick == div_q);
  wire [4:0] nlast     = long_q ? 5'(LONGN) : 5'(SHORTN);
  wire       frame_bit = (nfall < 5'(LEAD)) || (nfall >= 5'(SHORTN));

  assign busy = ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n      <= 1'b1;
      sclk      <= 1'b1;
      valid     <= 1'b0;
      result    <= '0;
      frame_err <= 1'b0;
      div_q     <= '0;
      tick      <= '0;
      long_q    <= 1'b0;
      err_q     <= 1'b0;
      nfall     <= '0;
      shreg     <= '0;
      qcnt      <= '0;
    end else begin
      valid <= 1'b0;
      if (cs_n) begin
        if (qcnt != '1) qcnt <= qcnt + 1'b1;
        if (accept) begin
          cs_n   <= 1'b0;
          qcnt   <= '0;
          tick   <= '0;
          nfall  <= '0;
          err_q  <= 1'b0;
          div_q  <= half_div;
          long_q <= long_frame;
        end
      end else if (!tick_hit) begin
        tick <= tick + 1'b1;
      end else begin
        tick <= '0;
        if (sclk) begin
          sclk  <= 1'b0;
          nfall <= nfall + 5'd1;
          if (frame_bit) err_q <= err_q | sdata;
          else           shreg <= {shreg[RES_W-2:0], sdata};
        end else begin
          sclk <= 1'b1;
          if (nfall == nlast) begin
            cs_n      <= 1'b1;
            valid     <= 1'b1;
            result    <= shreg;
            frame_err <= err_q;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int DIV_W   = 8,
  parameter int QUIET_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               long_frame,
  input logic [QUIET_W-1:0] quiet_min,
  input logic               cs_n,
  input logic               sclk,
  input logic               valid
);
  logic [QUIET_W:0] hi_run;
  logic [5:0]       nf;
  logic             sclk_d, mode_q;
  wire  [QUIET_W:0] gap_need = {1'b0, quiet_min} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      nf     <= '0;
      sclk_d <= 1'b1;
      mode_q <= 1'b0;
    end else begin
      sclk_d <= sclk;
      if (cs_n) begin
        if (hi_run != '1) hi_run <= hi_run + 1'b1;
        nf     <= '0;
        mode_q <= long_frame;
      end else begin
        hi_run <= '0;
        if (sclk_d && !sclk) nf <= nf + 6'd1;
      end
    end
  end

  // R2
  sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  // R3
  quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> hi_run >= gap_need);

  // R5
  fall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> nf == (mode_q ? 6'd24 : 6'd20));

  // R8
  valid_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> cs_n && $past(!cs_n));

  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
endmodule

bind adc_frame_reader adc_frame_reader_chk #(.DIV_W(DIV_W), .QUIET_W(QUIET_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .long_frame(long_frame), .quiet_min(quiet_min),
  .cs_n(cs_n), .sclk(sclk), .valid(valid)
);

// File: tb/adc_frame_reader_tb_top.sv
module adc_frame_reader_tb_top;
  localparam int CLK_P   = 10;
  localparam int DIV_W   = 4;
  localparam int QUIET_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, long_frame = 1'b0;
  logic [DIV_W-1:0]   half_div = '0;
  logic [QUIET_W-1:0] quiet_min = '0;
  logic sdata, cs_n, sclk, busy, valid, frame_err;
  logic [15:0] result;

  logic [23:0] fw = '0;
  int idx = 0, nfalls = 0, total = 0, fails = 0;
  logic [15:0] last_res = '0;

  always #(CLK_P/2) clk = ~clk;

  adc_frame_reader #(.DIV_W(DIV_W), .QUIET_W(QUIET_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .long_frame(long_frame),
    .half_div(half_div), .quiet_min(quiet_min), .sdata(sdata),
    .cs_n(cs_n), .sclk(sclk), .busy(busy), .result(result),
    .valid(valid), .frame_err(frame_err)
  );

  always @(negedge cs_n or negedge sclk) begin
    if (sclk) begin idx = 0; nfalls = 0; end
    else begin idx = idx + 1; nfalls = nfalls + 1; end
  end
  assign sdata = (idx < 24) ? fw[23-idx] : 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input int div, input bit mode, input logic [15:0] d,
                           input logic [3:0] lead, input logic [3:0] trail,
                           input bit disturb, input bit gap_chk);
    int hi, low, n;
    bit exp_err;
    n = mode ? 24 : 20;
    exp_err = (lead != 0) || (mode && trail != 0);
    fw = {lead, d, trail};
    half_div = DIV_W'(div);
    long_frame = mode;
    start = 1'b1;
    hi = 2;
    while (cs_n) begin
      @(negedge clk);
      if (cs_n) hi++;
    end
    if (gap_chk) chk(hi == int'(quiet_min) + 1, "R3 quiet gap", hi, int'(quiet_min) + 1);
    chk(sclk == 1'b1, "R2 sclk high at frame start", sclk, 1);
    low = 1;
    if (!disturb) start = 1'b0;
    else begin
      half_div = DIV_W'(div ^ 1);
      long_frame = ~mode;
    end
    while (!cs_n) begin
      @(negedge clk);
      if (!cs_n) low++;
    end
    start = 1'b0;
    chk(low == 2 * n * (div + 1), "R4 frame length", low, 2 * n * (div + 1));
    chk(nfalls == n, "R5 falling edges", nfalls, n);
    chk(valid == 1'b1, "R8 valid after release", valid, 1);
    chk(result == d, "R6 result", result, d);
    chk(frame_err == exp_err, "R7 frame_err", frame_err, exp_err);
    chk(sclk == 1'b1, "R2 sclk high at end", sclk, 1);
    last_res = d;
    @(negedge clk);
    chk(valid == 1'b0, "R8 valid one cycle", valid, 0);
    chk(result == last_res, "R8 result held", result, last_res);
  endtask

  function automatic logic [15:0] pat(input int i);
    case (i)
      0: pat = 16'h0000;
      1: pat = 16'hFFFF;
      2: pat = 16'hA5C3;
      default: pat = 16'h8001;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && sclk && !busy && !valid && result == 16'h0 && !frame_err,
        "R1 reset outputs", {cs_n, sclk, busy, valid, frame_err}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && sclk && !valid && result == 16'h0, "R1 after reset",
        {cs_n, sclk, valid}, 3'b110);
    repeat (4) @(negedge clk);
    for (int dv = 0; dv < 4; dv++)
      for (int m = 0; m < 2; m++)
        for (int p = 0; p < 4; p++)
          run_frame(dv, m[0], pat(p), 4'h0, 4'h0, 1'b0, 1'b0);
    for (int b = 0; b < 16; b++)
      run_frame(0, b[0], 16'h1 << b, 4'h0, 4'h0, 1'b0, 1'b0);
    run_frame(1, 1'b0, 16'h1234, 4'b0100, 4'h0, 1'b0, 1'b0);
    run_frame(1, 1'b1, 16'h4321, 4'b1000, 4'h0, 1'b0, 1'b0);
    run_frame(0, 1'b1, 16'h00FF, 4'h0, 4'b0001, 1'b0, 1'b0);
    run_frame(0, 1'b0, 16'hFF00, 4'h0, 4'b1111, 1'b0, 1'b0);
    run_frame(2, 1'b0, 16'hBEEF, 4'h0, 4'h0, 1'b1, 1'b0);
    run_frame(1, 1'b1, 16'h5A5A, 4'h0, 4'h0, 1'b1, 1'b0);
    quiet_min = QUIET_W'(5);
    repeat (8) @(negedge clk);
    run_frame(0, 1'b0, 16'h0F0F, 4'h0, 4'h0, 1'b0, 1'b0);
    run_frame(0, 1'b1, 16'hF0F0, 4'h0, 4'h0, 1'b0, 1'b1);
    run_frame(3, 1'b0, 16'h7FFE, 4'h0, 4'h0, 1'b0, 1'b1);
    quiet_min = QUIET_W'(9);
    run_frame(1, 1'b1, 16'hC001, 4'h0, 4'h0, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule